// File: doc/BRIEF.md
# Escape-Aware Opcode Fetch and Classify Unit

This unit is the first stage of a small byte-coded processor front end. It pulls instruction bytes one at a time from a byte-wide memory port and tracks the instruction pointer. For each instruction it works out how many opcode bytes it spans and which opcode class it belongs to. The two prefix bytes 0xF2 and 0xF3 and the escape byte 0x0F can open a longer opcode. Both prefix paths can themselves be followed by the 0x0F escape, which gives a third opcode byte. Operand bytes are not decoded and no instruction is executed. The unit only reports the opcode bytes, their class, their count and the address where the instruction began.

Which final opcode bytes are legal is set at configuration time. There is one legal-bit per byte value in each of six class tables. If the final byte of an instruction is not legal for its class, the unit reports a fault that says which byte position was rejected. The stop opcode 0xF4 moves the instruction pointer to a programmed end address. After a stop or a fault the unit issues no further fetches until reset. Decoding begins when the unit is started with a one-cycle start pulse. Memory requests and responses each use a valid/ready handshake, so memory latency may vary.

Top module: `opdec_top`

## Requirements
- R1: Out of reset the unit makes no memory request, shows no result, no stop and no fault, and its instruction pointer equals the RESET_IP parameter (default 1).
- R2: Each byte fetch requests the address held in the instruction pointer, holds request and address steady until accepted, and the pointer advances by exactly one on every accepted request, so successive fetched addresses are consecutive.
- R3: `dec_start` reports the instruction pointer value at which the first byte of the instruction was requested.
- R4: A first byte that is none of 0x0F, 0xF2, 0xF3, 0xF4 and is legal in the single-byte table (class 0) completes an instruction of length 1 with class 0.
- R5: A first byte of 0x0F fetches a second byte; if that byte is legal in the escape table the result is class 1 with length 2.
- R6: A first byte of 0xF2 (or 0xF3) followed by a byte other than 0x0F that is legal in that prefix table gives class 2 (or class 4) with length 2.
- R7: The sequences 0xF2 0x0F and 0xF3 0x0F fetch a third byte; if legal in the matching table the result is class 3 (or class 5) with length 3.
- R8: A first byte of 0xF4 completes a length-1 class-0 result, raises `halted`, loads the instruction pointer with `end_addr`, and no further requests follow.
- R9: A final byte that is not legal for its class raises `fault` with `fault_pos` = 1, 2 or 3 for the first, second or third byte, reports `dec_start`, produces no result and stops all further requests.
- R10: The legal tables are separate per class: writing with `cfg_set`=1 marks a byte legal only in class `cfg_cls`, and writing with `cfg_set`=0 makes it illegal again.
- R11: No request is made before the `go` pulse. The bytes 0x0F, 0xF2, 0xF3 and 0xF4 in the first position act as escape, prefix or stop whatever the single-byte table holds.
- R12: Result bytes are packed with the first byte in `dec_bytes[7:0]`, the second in [15:8] and the third in [23:16]; unused byte slots read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | One-cycle pulse that starts decoding |
| end_addr | input | AW | Address loaded into the pointer on a stop opcode |
| cfg_we | input | 1 | Legal-table write strobe |
| cfg_cls | input | 3 | Class table selected for the write (0..5) |
| cfg_op | input | 8 | Byte value written |
| cfg_set | input | 1 | 1 marks the byte legal, 0 illegal |
| mem_req_valid | output | 1 | Byte fetch request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Address of the requested byte |
| mem_rsp_valid | input | 1 | Returned byte is present |
| mem_rsp_ready | output | 1 | Unit waits for a returned byte |
| mem_rsp_data | input | 8 | Returned byte |
| dec_valid | output | 1 | One-cycle pulse: an instruction was classified |
| dec_class | output | 3 | Opcode class 0..5 |
| dec_bytes | output | 24 | Packed opcode bytes |
| dec_len | output | 2 | Number of opcode bytes (1..3) |
| dec_start | output | AW | Address of the first opcode byte |
| halted | output | 1 | Stop opcode seen; sticky until reset |
| fault | output | 1 | Illegal byte seen; sticky until reset |
| fault_pos | output | 2 | Position of the rejected byte (1..3) |
| ip_out | output | AW | Current instruction pointer |

## Verification
The assertions assume the memory gives exactly one response for each accepted request, never raises `mem_rsp_valid` while no request is outstanding, and holds it until `mem_rsp_ready`. They also assume `cfg_cls` stays below six on every table write. The bench's memory model only answers a request it has latched. Its acceptance and response delays come from a shift-register sequence (0 to 3 cycles of latency), and tables are written only before `go`, with legal class numbers.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

   localparam int OPW     = 8;
   localparam int MAX_LEN = 3;
   localparam int PW      = $clog2(MAX_LEN + 1);
   localparam int CW      = 3;
   localparam int NUM_CLS = 6;

   localparam logic [OPW-1:0] OP_ESCAPE = 8'h0F;
   localparam logic [OPW-1:0] OP_PFX_A  = 8'hF2;
   localparam logic [OPW-1:0] OP_PFX_B  = 8'hF3;
   localparam logic [OPW-1:0] OP_STOP   = 8'hF4;

   // class numbering is visible at the ports
   typedef enum logic [CW-1:0] {
      CLS_ONE    = 3'd0,
      CLS_ESC    = 3'd1,
      CLS_PA     = 3'd2,
      CLS_PA_ESC = 3'd3,
      CLS_PB     = 3'd4,
      CLS_PB_ESC = 3'd5
   } opcls_e;

   typedef enum logic [1:0] {
      ACT_MORE,
      ACT_DONE,
      ACT_STOP,
      ACT_FAIL
   } act_e;

   typedef enum logic [1:0] {
      C_WAIT,
      C_RUN,
      C_STOP
   } ctl_e;

   typedef enum logic [1:0] {
      F_IDLE,
      F_REQ,
      F_RSP
   } fst_e;

endpackage

// File: rtl/opdec_optable.sv
module opdec_optable
   import opdec_pkg::*;
#(
   parameter int N_CLS = NUM_CLS,
   parameter int N_OP  = 1 << OPW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [CW-1:0]  wr_cls,
   input  logic [OPW-1:0] wr_op,
   input  logic           wr_set,
   input  logic [CW-1:0]  rd_cls,
   input  logic [OPW-1:0] rd_op,
   output logic           rd_hit
);

   localparam int SLOTS = 1 << CW;

   if (N_CLS < 1 || N_CLS > SLOTS) begin : g_bad_cls
      $error("opdec_optable: N_CLS out of range");
   end
   if (N_OP != (1 << OPW)) begin : g_bad_op
      $error("opdec_optable: N_OP must cover every byte value");
   end

   logic [SLOTS-1:0] hit_vec;

   for (genvar g = 0; g < SLOTS; g++) begin : g_cls
      if (g < N_CLS) begin : g_tbl
         logic [N_OP-1:0] legal_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               legal_q <= '0;
            end else if (wr_en && (wr_cls == CW'(g))) begin
               legal_q[wr_op] <= wr_set;
            end
         end
         assign hit_vec[g] = legal_q[rd_op];
      end else begin : g_none
         assign hit_vec[g] = 1'b0;
      end
   end

   assign rd_hit = hit_vec[rd_cls];

   AST_CFG_CLASS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_cls) < N_CLS))
      else $error("table write to missing class"); // R10

endmodule

// File: rtl/opdec_fetch.sv
module opdec_fetch
   import opdec_pkg::*;
#(
   parameter int          AW       = 32,
   parameter int unsigned RESET_IP = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           fetch_en,
   input  logic           load_en,
   input  logic [AW-1:0]  load_val,
   output logic           req_valid,
   input  logic           req_ready,
   output logic [AW-1:0]  req_addr,
   input  logic           rsp_valid,
   output logic           rsp_ready,
   input  logic [OPW-1:0] rsp_data,
   output logic           byte_valid,
   output logic [OPW-1:0] byte_data,
   output logic           req_fire,
   output logic [AW-1:0]  ip
);

   fst_e          st_q;
   logic [AW-1:0] ip_q;

   assign req_valid  = (st_q == F_REQ);
   assign req_addr   = ip_q;
   assign req_fire   = req_valid && req_ready;
   assign rsp_ready  = (st_q == F_RSP);
   assign byte_valid = rsp_ready && rsp_valid;
   assign byte_data  = rsp_data;
   assign ip         = ip_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= F_IDLE;
         ip_q <= AW'(RESET_IP);
      end else begin
         unique case (st_q)
            F_IDLE: if (fetch_en) st_q <= F_REQ;
            F_REQ: begin
               if (req_ready) begin
                  ip_q <= ip_q + AW'(1);
                  st_q <= F_RSP;
               end
            end
            F_RSP: if (rsp_valid) st_q <= F_IDLE;
            default: st_q <= F_IDLE;
         endcase
         if (load_en) ip_q <= load_val;
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)))
      else $error("request dropped or address moved"); // R2

   AST_IP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      req_fire |=> (ip_q == $past(req_addr) + AW'(1)))
      else $error("pointer did not advance by one"); // R2

   AST_RSP_SOLICITED: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (st_q == F_RSP))
      else $error("response without outstanding request"); // R2

endmodule

// File: rtl/opdec_classify.sv
module opdec_classify
   import opdec_pkg::*;
(
   input  logic [PW-1:0]  pos,
   input  opcls_e         path,
   input  logic [OPW-1:0] ob,
   input  logic           hit,
   output opcls_e         look_cls,
   output act_e           act,
   output opcls_e         nxt_path
);

   always_comb begin
      look_cls = (pos == '0) ? CLS_ONE : path;
      nxt_path = path;
      act      = hit ? ACT_DONE : ACT_FAIL;
      if (pos == '0) begin
         unique case (ob)
            OP_ESCAPE: begin act = ACT_MORE; nxt_path = CLS_ESC; end
            OP_PFX_A:  begin act = ACT_MORE; nxt_path = CLS_PA;  end
            OP_PFX_B:  begin act = ACT_MORE; nxt_path = CLS_PB;  end
            OP_STOP:   act = ACT_STOP;
            default:   ;
         endcase
      end else if (pos == PW'(1) && ob == OP_ESCAPE) begin
         if (path == CLS_PA) begin
            act      = ACT_MORE;
            nxt_path = CLS_PA_ESC;
         end else if (path == CLS_PB) begin
            act      = ACT_MORE;
            nxt_path = CLS_PB_ESC;
         end
      end
   end

endmodule

// File: rtl/opdec_top.sv
module opdec_top
   import opdec_pkg::*;
#(
   parameter int          AW       = 32,
   parameter int unsigned RESET_IP = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   go,
   input  logic [AW-1:0]          end_addr,
   input  logic                   cfg_we,
   input  logic [CW-1:0]          cfg_cls,
   input  logic [OPW-1:0]         cfg_op,
   input  logic                   cfg_set,
   output logic                   mem_req_valid,
   input  logic                   mem_req_ready,
   output logic [AW-1:0]          mem_req_addr,
   input  logic                   mem_rsp_valid,
   output logic                   mem_rsp_ready,
   input  logic [OPW-1:0]         mem_rsp_data,
   output logic                   dec_valid,
   output logic [CW-1:0]          dec_class,
   output logic [MAX_LEN*OPW-1:0] dec_bytes,
   output logic [PW-1:0]          dec_len,
   output logic [AW-1:0]          dec_start,
   output logic                   halted,
   output logic                   fault,
   output logic [PW-1:0]          fault_pos,
   output logic [AW-1:0]          ip_out
);

   if (AW < 8 || AW > 64) begin : g_bad_aw
      $error("opdec_top: AW must be 8..64");
   end

   typedef logic [MAX_LEN-1:0][OPW-1:0] obytes_t;

   ctl_e          cst_q;
   logic [PW-1:0] pos_q;
   opcls_e        path_q;
   obytes_t       bytes_q, bytes_nx;
   logic [AW-1:0] start_q;

   logic           f_bvalid, f_fire, f_load;
   logic [OPW-1:0] f_byte;
   opcls_e         look_cls, nxt_path;
   act_e           act;
   logic           tbl_hit;

   opdec_fetch #(.AW(AW), .RESET_IP(RESET_IP)) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .fetch_en   (cst_q == C_RUN),
      .load_en    (f_load),
      .load_val   (end_addr),
      .req_valid  (mem_req_valid),
      .req_ready  (mem_req_ready),
      .req_addr   (mem_req_addr),
      .rsp_valid  (mem_rsp_valid),
      .rsp_ready  (mem_rsp_ready),
      .rsp_data   (mem_rsp_data),
      .byte_valid (f_bvalid),
      .byte_data  (f_byte),
      .req_fire   (f_fire),
      .ip         (ip_out)
   );

   opdec_optable #(.N_CLS(NUM_CLS)) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_we),
      .wr_cls (cfg_cls),
      .wr_op  (cfg_op),
      .wr_set (cfg_set),
      .rd_cls (look_cls),
      .rd_op  (f_byte),
      .rd_hit (tbl_hit)
   );

   opdec_classify u_cls (
      .pos      (pos_q),
      .path     (path_q),
      .ob       (f_byte),
      .hit      (tbl_hit),
      .look_cls (look_cls),
      .act      (act),
      .nxt_path (nxt_path)
   );

   always_comb begin
      bytes_nx = bytes_q;
      for (int k = 0; k < MAX_LEN; k++) begin
         if (pos_q == PW'(k)) bytes_nx[k] = f_byte;
      end
   end

   assign f_load = f_bvalid && (cst_q == C_RUN) && (act == ACT_STOP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cst_q     <= C_WAIT;
         pos_q     <= '0;
         path_q    <= CLS_ONE;
         bytes_q   <= '0;
         start_q   <= '0;
         dec_valid <= 1'b0;
         dec_class <= '0;
         dec_bytes <= '0;
         dec_len   <= '0;
         dec_start <= '0;
         halted    <= 1'b0;
         fault     <= 1'b0;
         fault_pos <= '0;
      end else begin
         dec_valid <= 1'b0;
         if (cst_q == C_WAIT && go) cst_q <= C_RUN;
         if (f_fire && pos_q == '0) start_q <= mem_req_addr;
         if (f_bvalid && cst_q == C_RUN) begin
            unique case (act)
               ACT_MORE: begin
                  pos_q   <= pos_q + PW'(1);
                  path_q  <= nxt_path;
                  bytes_q <= bytes_nx;
               end
               ACT_DONE, ACT_STOP: begin
                  dec_valid <= 1'b1;
                  dec_class <= look_cls;
                  dec_bytes <= bytes_nx;
                  dec_len   <= pos_q + PW'(1);
                  dec_start <= start_q;
                  pos_q     <= '0;
                  path_q    <= CLS_ONE;
                  bytes_q   <= '0;
                  if (act == ACT_STOP) begin
                     halted <= 1'b1;
                     cst_q  <= C_STOP;
                  end
               end
               default: begin
                  fault     <= 1'b1;
                  fault_pos <= pos_q + PW'(1);
                  dec_start <= start_q;
                  cst_q     <= C_STOP;
               end
            endcase
         end
      end
   end

   AST_QUIET_BEFORE_GO: assert property (@(posedge clk) disable iff (!rst_n)
      (cst_q == C_WAIT) |-> !mem_req_valid)
      else $error("fetch before start"); // R11

   AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (halted || fault) |-> !mem_req_valid)
      else $error("fetch after stop or fault"); // R9

   AST_STOP_LOADS_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted) |-> (ip_out == $past(end_addr)))
      else $error("stop did not load end address"); // R8

   AST_NO_RESULT_AFTER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> !fault)
      else $error("result alongside fault"); // R9

   AST_THREE_BYTE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> ((dec_len == PW'(3)) ==
                     (dec_class == CLS_PA_ESC || dec_class == CLS_PB_ESC)))
      else $error("length and class disagree"); // R7

   AST_ESC_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_class == CLS_ESC) |-> (dec_len == PW'(2)))
      else $error("escape class with wrong length"); // R5

endmodule

// File: tb/opdec_top_tb.sv
`timescale 1ns/1ps
module opdec_top_tb;

   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          go = 1'b0;
   logic [AW-1:0] end_addr = 32'h40;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_cls = '0;
   logic [7:0]    cfg_op = '0;
   logic          cfg_set = 1'b0;
   logic          mem_req_valid, mem_req_ready, mem_rsp_valid, mem_rsp_ready;
   logic [AW-1:0] mem_req_addr;
   logic [7:0]    mem_rsp_data;
   logic          dec_valid, halted, fault;
   logic [2:0]    dec_class;
   logic [23:0]   dec_bytes;
   logic [1:0]    dec_len, fault_pos;
   logic [AW-1:0] dec_start, ip_out;

   always #4 clk = ~clk;   // 125 MHz

   opdec_top #(.AW(AW), .RESET_IP(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .go(go), .end_addr(end_addr),
      .cfg_we(cfg_we), .cfg_cls(cfg_cls), .cfg_op(cfg_op), .cfg_set(cfg_set),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
      .dec_valid(dec_valid), .dec_class(dec_class), .dec_bytes(dec_bytes),
      .dec_len(dec_len), .dec_start(dec_start), .halted(halted),
      .fault(fault), .fault_pos(fault_pos), .ip_out(ip_out)
   );

   int n_checks = 0;
   int n_fail   = 0;

   task automatic check(input bit ok, input string req,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   logic [7:0]    mem [0:255];
   logic [15:0]   lfsr;
   logic          pend;
   logic [1:0]    pdly;
   logic [AW-1:0] paddr, last_addr, first_addr;
   int            fetch_cnt, seq_bad;

   always @(posedge clk) begin
      if (!rst_n) begin
         lfsr          <= 16'hACE1;
         mem_req_ready <= 1'b0;
         mem_rsp_valid <= 1'b0;
         mem_rsp_data  <= '0;
         pend          <= 1'b0;
         pdly          <= '0;
         paddr         <= '0;
         fetch_cnt     <= 0;
         seq_bad       <= 0;
         last_addr     <= '0;
         first_addr    <= '0;
      end else begin
         lfsr          <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         mem_req_ready <= lfsr[0] | lfsr[3];
         if (mem_rsp_valid && mem_rsp_ready) mem_rsp_valid <= 1'b0;
         if (pend) begin
            if (pdly == 2'd0) begin
               mem_rsp_valid <= 1'b1;
               mem_rsp_data  <= mem[paddr[7:0]];
               pend          <= 1'b0;
            end else begin
               pdly <= pdly - 2'd1;
            end
         end
         if (mem_req_valid && mem_req_ready) begin
            pend      <= 1'b1;
            paddr     <= mem_req_addr;
            pdly      <= lfsr[2:1];
            fetch_cnt <= fetch_cnt + 1;
            if (fetch_cnt == 0) first_addr <= mem_req_addr;
            else if (mem_req_addr != last_addr + 1) seq_bad <= seq_bad + 1;
            last_addr <= mem_req_addr;
         end
      end
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      bit          is_fault;
      logic [63:0] val;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   logic fault_prev = 1'b0;

   task automatic exp_dec(input logic [2:0] cls, input logic [23:0] b,
                          input logic [1:0] len, input bit stop,
                          input logic [31:0] start, input string tag);
      exp_t e;
      e.is_fault = 1'b0;
      e.val      = {2'b0, cls, len, stop, b, start};
      e.tag      = tag;
      exp_q.push_back(e);
   endtask

   task automatic exp_fault(input logic [1:0] p, input logic [31:0] start,
                            input string tag);
      exp_t e;
      e.is_fault = 1'b1;
      e.val      = {30'b0, p, start};
      e.tag      = tag;
      exp_q.push_back(e);
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (dec_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R4 unexpected result", {40'b0, dec_bytes}, 64'b0);
            end else begin
               exp_t e;
               logic [63:0] a;
               e = exp_q.pop_front();
               a = {2'b0, dec_class, dec_len, halted, dec_bytes, dec_start};
               check(!e.is_fault && a == e.val, e.tag, a, e.val);
            end
         end
         if (fault && !fault_prev) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R9 unexpected fault", {62'b0, fault_pos}, 64'b0);
            end else begin
               exp_t e;
               logic [63:0] a;
               e = exp_q.pop_front();
               a = {30'b0, fault_pos, dec_start};
               check(e.is_fault && a == e.val, e.tag, a, e.val);
            end
         end
         fault_prev <= fault;
      end else begin
         fault_prev <= 1'b0;
      end
   end

   // ---------------- driver tasks ----------------
   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      go    = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      exp_q.delete();
   endtask

   task automatic cfg(input logic [2:0] c, input logic [7:0] op, input bit s);
      @(negedge clk);
      cfg_we  = 1'b1;
      cfg_cls = c;
      cfg_op  = op;
      cfg_set = s;
      @(negedge clk);
      cfg_we  = 1'b0;
   endtask

   task automatic load_tables();
      cfg(3'd0, 8'h90, 1'b1);
      cfg(3'd0, 8'h01, 1'b1);
      cfg(3'd0, 8'hC3, 1'b1);
      cfg(3'd1, 8'h84, 1'b1);
      cfg(3'd1, 8'hAF, 1'b1);
      cfg(3'd2, 8'hA5, 1'b1);
      cfg(3'd3, 8'h10, 1'b1);
      cfg(3'd4, 8'hAB, 1'b1);
      cfg(3'd5, 8'h2C, 1'b1);
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
   endtask

   task automatic start_and_wait(input string tag);
      int waited;
      @(negedge clk);
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      waited = 0;
      while (!(halted || fault) && waited < 3000) begin
         @(negedge clk);
         waited++;
      end
      check(waited < 3000, {tag, " did not stop"}, 64'(waited), 64'd3000);
      repeat (20) @(negedge clk);
   endtask

   task automatic post_checks(input string tag, input int exp_fetch,
                              input logic [31:0] exp_ip);
      check(fetch_cnt == exp_fetch, {tag, " R2 fetch count"}, 64'(fetch_cnt), 64'(exp_fetch));
      check(seq_bad == 0, {tag, " R2 consecutive addresses"}, 64'(seq_bad), 64'd0);
      check(first_addr == 32'd1, {tag, " R3 first fetch address"}, 64'(first_addr), 64'd1);
      check(ip_out == exp_ip, {tag, " R8 final pointer"}, 64'(ip_out), 64'(exp_ip));
      check(exp_q.size() == 0, {tag, " scoreboard drained"}, 64'(exp_q.size()), 64'd0);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      clear_mem();
      do_reset();
      // R1 reset state
      @(negedge clk);
      check(!mem_req_valid && !dec_valid && !halted && !fault,
            "R1 idle outputs", {60'b0, mem_req_valid, dec_valid, halted, fault}, 64'b0);
      check(ip_out == 32'd1, "R1 reset pointer", 64'(ip_out), 64'd1);

      // R11 no fetch before go
      load_tables();
      repeat (10) @(negedge clk);
      check(fetch_cnt == 0, "R11 no request before go", 64'(fetch_cnt), 64'd0);

      // Program A: every class, then stop (R4 R5 R6 R7 R8 R12)
      clear_mem();
      mem[1]  = 8'h90;
      mem[2]  = 8'h0F; mem[3]  = 8'h84;
      mem[4]  = 8'hF2; mem[5]  = 8'hA5;
      mem[6]  = 8'hF2; mem[7]  = 8'h0F; mem[8]  = 8'h10;
      mem[9]  = 8'hF3; mem[10] = 8'hAB;
      mem[11] = 8'hF3; mem[12] = 8'h0F; mem[13] = 8'h2C;
      mem[14] = 8'h01;
      mem[15] = 8'hF4;
      exp_dec(3'd0, 24'h000090, 2'd1, 1'b0, 32'd1,  "R4 single byte 90");
      exp_dec(3'd1, 24'h00840F, 2'd2, 1'b0, 32'd2,  "R5 escape 0F 84");
      exp_dec(3'd2, 24'h00A5F2, 2'd2, 1'b0, 32'd4,  "R6 prefix F2 A5");
      exp_dec(3'd3, 24'h100FF2, 2'd3, 1'b0, 32'd6,  "R7 F2 0F 10");
      exp_dec(3'd4, 24'h00ABF3, 2'd2, 1'b0, 32'd9,  "R6 prefix F3 AB");
      exp_dec(3'd5, 24'h2C0FF3, 2'd3, 1'b0, 32'd11, "R7 F3 0F 2C");
      exp_dec(3'd0, 24'h000001, 2'd1, 1'b0, 32'd14, "R12 single byte 01 packing");
      exp_dec(3'd0, 24'h0000F4, 2'd1, 1'b1, 32'd15, "R8 stop opcode");
      start_and_wait("progA");
      post_checks("progA", 15, 32'h40);
      check(!fault, "R8 no fault on stop", {63'b0, fault}, 64'd0);

      // Program B: legal in class 0 only, used after escape (R10, R9 pos 2)
      do_reset();
      load_tables();
      clear_mem();
      mem[1] = 8'h0F; mem[2] = 8'h90;
      exp_fault(2'd2, 32'd1, "R10 byte legal only in single table");
      start_and_wait("progB");
      post_checks("progB", 2, 32'd3);

      // Program C: legal bit set then cleared (R10, R9 pos 1)
      do_reset();
      load_tables();
      cfg(3'd0, 8'h55, 1'b1);
      cfg(3'd0, 8'h55, 1'b0);
      clear_mem();
      mem[1] = 8'h55;
      exp_fault(2'd1, 32'd1, "R9 first byte illegal after clear");
      start_and_wait("progC");
      post_checks("progC", 1, 32'd2);
      check(!halted, "R9 fault does not stop-load", {63'b0, halted}, 64'd0);

      // Program D: third byte legal only under the other prefix (R9 pos 3)
      do_reset();
      load_tables();
      clear_mem();
      mem[1] = 8'hF3; mem[2] = 8'h0F; mem[3] = 8'h10;
      exp_fault(2'd3, 32'd1, "R9 third byte illegal");
      start_and_wait("progD");
      post_checks("progD", 3, 32'd4);

      // Program E: second byte legal under other prefix (R10 R9 pos 2)
      do_reset();
      load_tables();
      clear_mem();
      mem[1] = 8'hF2; mem[2] = 8'hAB;
      exp_fault(2'd2, 32'd1, "R10 prefix tables separate");
      start_and_wait("progE");
      post_checks("progE", 2, 32'd3);

      // Program F: 0F marked legal in single table still escapes (R11)
      do_reset();
      load_tables();
      cfg(3'd0, 8'h0F, 1'b1);
      clear_mem();
      mem[1] = 8'h0F; mem[2] = 8'hAF;
      mem[3] = 8'hC3;
      mem[4] = 8'hF4;
      exp_dec(3'd1, 24'h00AF0F, 2'd2, 1'b0, 32'd1, "R11 escape wins over table");
      exp_dec(3'd0, 24'h0000C3, 2'd1, 1'b0, 32'd3, "R4 single byte C3");
      exp_dec(3'd0, 24'h0000F4, 2'd1, 1'b1, 32'd4, "R8 stop after two");
      start_and_wait("progF");
      post_checks("progF", 4, 32'h40);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule